// File: doc/BRIEF.md
# DRAM Rank Power-Down Idle Controller

This block drives the clock-enable lines of a group of DDR3 ranks. It moves each rank into precharge power-down once the rank has gone without work for a programmable stretch, and brings it back out when work arrives. For every rank it watches a request-pending flag from the memory controller's queue and counts DRAM clocks in which nothing is pending. When the count reaches the programmed idle limit, it lowers that rank's clock enable and emits a one-cycle entry strobe.

When a request shows up for a powered-down rank, the block raises clock enable again and emits a one-cycle exit strobe. It then holds the rank's command-allowed flag low until a programmable exit wait has run out. Every toggle of clock enable respects a programmable minimum time at each level. Only the fast-exit form of precharge power-down is produced.

In sharing mode, ranks 2k and 2k+1 behave as one clock-enable group. Both ranks must have been idle for the full limit before the group's lines drop, and a request to either rank wakes both. All timing inputs are counted in DRAM clocks.

Top module: `pd_rank_ctrl`

## Requirements
- R1: After reset every cke_o bit is 1, every cmd_ok_o bit is 1, and every pd_enter_o and pd_exit_o bit is 0.
- R2: With idle_limit = L (L > 0), a rank whose req_pending is sampled 0 on L consecutive clock edges shows cke_o = 0 after the next edge (edge L+1), and shows 1 after edge L.
- R3: A req_pending value of 1 sampled on any edge restarts the rank's idle count from zero, so a further L+1 idle edges are needed before cke_o drops.
- R4: With share_cke = 1, ranks 2k and 2k+1 drop cke_o together only after both have been idle for the full limit, and a request to either rank raises both lines on the same edge.
- R5: A request to a rank whose cke_o is 0 raises cke_o on the next clock edge once the minimum level time is met.
- R6: After cke_o rises with exit_wait = W, cmd_ok_o for that rank is 0 for W cycles and returns to 1 after edge W. While cke_o is 0, cmd_ok_o is 0.
- R7: Once cke_o changes, it keeps its new level for at least cke_min_width cycles before it changes again. A value of 0 or 1 imposes no extra hold.
- R8: idle_limit = 0 disables automatic power-down entry: cke_o stays 1 and pd_enter_o stays 0 however long the ranks are idle.
- R9: pd_enter_o is 1 for exactly the first cycle in which cke_o is 0, and pd_exit_o is 1 for exactly the first cycle in which cke_o is back at 1.
- R10: With share_cke = 0, each rank's clock enable depends only on its own request flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| share_cke | input | 1 | 1: ranks 2k and 2k+1 share one clock-enable group |
| idle_limit | input | 8 | Idle clocks before power-down entry; 0 disables entry |
| exit_wait | input | 3 | Clocks after clock-enable rises before commands are allowed |
| cke_min_width | input | 3 | Minimum clocks clock enable stays at one level |
| req_pending | input | NUM_RANKS | Per-rank request-pending flag from the queue |
| cke_o | output | NUM_RANKS | Per-rank clock-enable line |
| pd_enter_o | output | NUM_RANKS | One-cycle strobe in the first power-down cycle |
| pd_exit_o | output | NUM_RANKS | One-cycle strobe in the first cycle after exit |
| cmd_ok_o | output | NUM_RANKS | 1 when commands to the rank are allowed |

## Verification
Each result has a fixed latency from the edge that samples its cause. Power-down entry appears after edge L+1 counted from the first idle sample. Exit appears after the first edge that sees the request. Command-allowed returns after edge W following the exit, and a held toggle is released after the edge on which the level count reaches the minimum width. The bench changes inputs on the falling clock edge, counts rising edges from that point, and samples outputs on a falling edge. It checks the cycle just before each due edge as well as the cycle at that edge, so an early or a late transition both fail.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int IDLE_W = 8;
    localparam int XW_W   = 3;
    localparam int MW_W   = 3;

    typedef enum logic {
        LVL_DOWN = 1'b0,
        LVL_UP   = 1'b1
    } cke_lvl_e;

    typedef struct packed {
        logic [IDLE_W-1:0] idle_limit;
        logic [XW_W-1:0]   exit_wait;
        logic [MW_W-1:0]   min_width;
    } pd_timing_t;

    function automatic logic [MW_W-1:0] width_sat_inc(input logic [MW_W-1:0] v);
        return (v == {MW_W{1'b1}}) ? v : v + MW_W'(1);
    endfunction

    function automatic logic [IDLE_W-1:0] idle_sat_inc(input logic [IDLE_W-1:0] v);
        return (v == {IDLE_W{1'b1}}) ? v : v + IDLE_W'(1);
    endfunction

endpackage

// File: rtl/pd_idle_timer.sv
module pd_idle_timer
    import pd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [IDLE_W-1:0] limit,
    output logic              idle_o
);

    logic [IDLE_W-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt <= '0;
        end else if (req) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_sat_inc(idle_cnt);
        end
    end

    assign idle_o = (limit != '0) && (idle_cnt >= limit);

    // R3
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> (idle_cnt == '0));

endmodule

// File: rtl/pd_cke_fsm.sv
module pd_cke_fsm
    import pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       grp_idle,
    input  logic       grp_wake,
    input  pd_timing_t cfg,
    output logic       cke_o,
    output logic       enter_o,
    output logic       exit_o,
    output logic       cmd_ok_o
);

    cke_lvl_e          lvl_q;
    logic [MW_W-1:0]   lvl_age;
    logic [XW_W-1:0]   xw_cnt;
    logic              may_toggle;
    logic              go_down;
    logic              go_up;

    assign may_toggle = (lvl_age >= cfg.min_width);
    assign go_down    = (lvl_q == LVL_UP) && grp_idle && !grp_wake
                        && may_toggle && (xw_cnt == '0);
    assign go_up      = (lvl_q == LVL_DOWN) && grp_wake && may_toggle;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= LVL_UP;
            lvl_age <= {MW_W{1'b1}};
            xw_cnt  <= '0;
            enter_o <= 1'b0;
            exit_o  <= 1'b0;
        end else begin
            enter_o <= go_down;
            exit_o  <= go_up;
            if (go_down) begin
                lvl_q   <= LVL_DOWN;
                lvl_age <= MW_W'(1);
                xw_cnt  <= '0;
            end else if (go_up) begin
                lvl_q   <= LVL_UP;
                lvl_age <= MW_W'(1);
                xw_cnt  <= cfg.exit_wait;
            end else begin
                lvl_age <= width_sat_inc(lvl_age);
                if (xw_cnt != '0) begin
                    xw_cnt <= xw_cnt - XW_W'(1);
                end
            end
        end
    end

    assign cke_o    = (lvl_q == LVL_UP);
    assign cmd_ok_o = (lvl_q == LVL_UP) && (xw_cnt == '0);

    // R7
    min_width_chk: assert property (@(posedge clk) disable iff (rst)
        (cke_o != $past(cke_o)) |-> ($past(lvl_age) >= $past(cfg.min_width)));

    // R9
    enter_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        enter_o |-> (!cke_o && $past(cke_o)));

    // R9
    exit_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        exit_o |-> (cke_o && !$past(cke_o)));

    // R6
    exit_wait_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cke_o) && ($past(cfg.exit_wait) != '0)) |-> !cmd_ok_o);

    // R5
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && grp_wake && may_toggle) |=> cke_o);

endmodule

// File: rtl/pd_rank_ctrl.sv
module pd_rank_ctrl
    import pd_pkg::*;
#(
    parameter int NUM_RANKS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  share_cke,
    input  logic [IDLE_W-1:0]     idle_limit,
    input  logic [XW_W-1:0]       exit_wait,
    input  logic [MW_W-1:0]       cke_min_width,
    input  logic [NUM_RANKS-1:0]  req_pending,
    output logic [NUM_RANKS-1:0]  cke_o,
    output logic [NUM_RANKS-1:0]  pd_enter_o,
    output logic [NUM_RANKS-1:0]  pd_exit_o,
    output logic [NUM_RANKS-1:0]  cmd_ok_o
);

    localparam int NUM_PAIRS = NUM_RANKS / 2;

    pd_timing_t             cfg;
    logic [NUM_RANKS-1:0]   rank_idle;
    logic [NUM_RANKS-1:0]   grp_idle;
    logic [NUM_RANKS-1:0]   grp_wake;

    assign cfg.idle_limit = idle_limit;
    assign cfg.exit_wait  = exit_wait;
    assign cfg.min_width  = cke_min_width;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        pd_idle_timer u_idle (
            .clk    (clk),
            .rst    (rst),
            .req    (req_pending[r]),
            .limit  (cfg.idle_limit),
            .idle_o (rank_idle[r])
        );

        pd_cke_fsm u_fsm (
            .clk      (clk),
            .rst      (rst),
            .grp_idle (grp_idle[r]),
            .grp_wake (grp_wake[r]),
            .cfg      (cfg),
            .cke_o    (cke_o[r]),
            .enter_o  (pd_enter_o[r]),
            .exit_o   (pd_exit_o[r]),
            .cmd_ok_o (cmd_ok_o[r])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        localparam int LO = 2 * p;
        localparam int HI = 2 * p + 1;
        logic pair_idle;
        logic pair_wake;

        assign pair_idle = rank_idle[LO] && rank_idle[HI];
        assign pair_wake = req_pending[LO] || req_pending[HI];

        always_comb begin
            if (share_cke) begin
                grp_idle[LO] = pair_idle;
                grp_idle[HI] = pair_idle;
                grp_wake[LO] = pair_wake;
                grp_wake[HI] = pair_wake;
            end else begin
                grp_idle[LO] = rank_idle[LO];
                grp_idle[HI] = rank_idle[HI];
                grp_wake[LO] = req_pending[LO];
                grp_wake[HI] = req_pending[HI];
            end
        end

        // R4
        shared_both_idle_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(share_cke) && (pd_enter_o[LO] || pd_enter_o[HI]))
            |-> ($past(rank_idle[LO]) && $past(rank_idle[HI])));
    end

    if ((NUM_RANKS % 2) == 1) begin : g_odd
        assign grp_idle[NUM_RANKS-1] = rank_idle[NUM_RANKS-1];
        assign grp_wake[NUM_RANKS-1] = req_pending[NUM_RANKS-1];
    end

    // R8
    zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(idle_limit) == '0) |-> (pd_enter_o == '0));

endmodule

// File: tb/pd_rank_ctrl_tb_top.sv
module pd_rank_ctrl_tb_top;

    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          share_cke = 1'b0;
    logic [7:0]    idle_limit = '0;
    logic [2:0]    exit_wait = '0;
    logic [2:0]    cke_min_width = '0;
    logic [NR-1:0] req_pending = '1;
    logic [NR-1:0] cke_o, pd_enter_o, pd_exit_o, cmd_ok_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pd_rank_ctrl #(.NUM_RANKS(NR)) dut_i (
        .clk(clk), .rst(rst), .share_cke(share_cke), .idle_limit(idle_limit),
        .exit_wait(exit_wait), .cke_min_width(cke_min_width),
        .req_pending(req_pending), .cke_o(cke_o), .pd_enter_o(pd_enter_o),
        .pd_exit_o(pd_exit_o), .cmd_ok_o(cmd_ok_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wake_all();
        req_pending = '1;
        edges(10);
    endtask

    task automatic t_reset();
        check("R1", "cke", cke_o, 4'hF);
        check("R1", "cmd_ok", cmd_ok_o, 4'hF);
        check("R1", "enter", pd_enter_o, 4'h0);
        check("R1", "exit", pd_exit_o, 4'h0);
    endtask

    task automatic t_entry();
        share_cke = 0; idle_limit = 8'd4; exit_wait = 3'd3; cke_min_width = 3'd0;
        wake_all();
        req_pending[0] = 1'b0;
        edges(4);
        check("R2", "cke before limit", cke_o, 4'hF);
        edges(1);
        check("R2", "cke after limit", cke_o, 4'hE);
        check("R9", "enter strobe", pd_enter_o, 4'h1);
        check("R6", "cmd_ok while down", cmd_ok_o, 4'hE);
        edges(1);
        check("R9", "enter strobe one cycle", pd_enter_o, 4'h0);
        check("R10", "other ranks up", cke_o, 4'hE);
    endtask

    task automatic t_exit();
        req_pending[0] = 1'b1;
        edges(1);
        check("R5", "cke raised", cke_o, 4'hF);
        check("R9", "exit strobe", pd_exit_o, 4'h1);
        check("R6", "cmd blocked w1", cmd_ok_o, 4'hE);
        edges(1);
        check("R9", "exit strobe one cycle", pd_exit_o, 4'h0);
        check("R6", "cmd blocked w2", cmd_ok_o, 4'hE);
        edges(1);
        check("R6", "cmd blocked w3", cmd_ok_o, 4'hE);
        edges(1);
        check("R6", "cmd allowed", cmd_ok_o, 4'hF);
    endtask

    task automatic t_restart();
        share_cke = 0; idle_limit = 8'd4; exit_wait = 3'd0; cke_min_width = 3'd0;
        wake_all();
        req_pending[1] = 1'b0;
        edges(3);
        req_pending[1] = 1'b1;
        edges(1);
        req_pending[1] = 1'b0;
        edges(4);
        check("R3", "count restarted", cke_o, 4'hF);
        edges(1);
        check("R3", "drop after full limit", cke_o, 4'hD);
    endtask

    task automatic t_zero_limit();
        int seen = 0;
        idle_limit = 8'd0;
        wake_all();
        req_pending = '0;
        for (int i = 0; i < 300; i++) begin
            edges(1);
            if (pd_enter_o != '0) seen++;
        end
        check("R8", "cke stays up", cke_o, 4'hF);
        check("R8", "no enter strobes", seen, 0);
    endtask

    task automatic t_shared();
        share_cke = 1; idle_limit = 8'd3; exit_wait = 3'd0; cke_min_width = 3'd0;
        wake_all();
        req_pending[0] = 1'b0;
        edges(6);
        check("R4", "one idle rank keeps pair up", cke_o, 4'hF);
        req_pending[1] = 1'b0;
        edges(3);
        check("R4", "partner not yet idle", cke_o, 4'hF);
        edges(1);
        check("R4", "pair drops together", cke_o, 4'hC);
        req_pending[1] = 1'b1;
        edges(1);
        check("R4", "partner wakes pair", cke_o, 4'hF);
        share_cke = 0;
    endtask

    task automatic t_min_width();
        share_cke = 0; idle_limit = 8'd1; exit_wait = 3'd0; cke_min_width = 3'd5;
        wake_all();
        req_pending[2] = 1'b0;
        edges(2);
        check("R7", "rank down", cke_o, 4'hB);
        req_pending[2] = 1'b1;
        edges(4);
        check("R7", "held low", cke_o, 4'hB);
        edges(1);
        check("R7", "released after width", cke_o, 4'hF);
        cke_min_width = 3'd0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        edges(3);
        rst = 1'b0;
        edges(1);
        t_reset();
        t_entry();
        t_exit();
        t_restart();
        t_zero_limit();
        t_shared();
        t_min_width();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule